// File: doc/BRIEF.md
# Underflow denormalize and round unit

This unit takes an intermediate floating-point result that is too small for its destination format and turns it into a correctly rounded denormal. The operand comes in normalized. It has a sign, a 15-bit biased exponent (extended bias) and a 64-bit mantissa whose integer bit is explicit. The unit holds the magnitude with the sign set aside. It then moves the mantissa one place right per clock and raises the exponent by one each time, until the exponent reaches the denormal threshold of the effective precision. Every bit that leaves the mantissa is kept as guard or sticky information. When the shift is done, the unit rounds in the selected mode and puts the sign back.

The result is returned with an inexact flag. A result written to a register also gets zero and negative condition flags. A result bound for memory in single or double format has its exponent lowered by one when the rounded mantissa has no integer bit, because the denormal bias is one below the normal bias. One operand is accepted at a time through a valid/ready handshake, and exactly one result comes back for each accepted operand.

Top module: `ufr_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: While the exponent is below the threshold, each clock shifts the mantissa right by one place and adds one to the exponent. The shifted result carries the threshold exponent.
- R3: The effective precision code selects the threshold and the kept width. Code 0 is extended: 64 bits, threshold 0x0000. Code 1 is single: 24 bits, threshold 0x3F81. Code 2 is double: 53 bits, threshold 0x3C01. Code 3 behaves as extended.
- R4: An operation code of 0x30 or 0x33 forces single precision whatever `in_prec` holds. Every other code, for example 0x31, uses `in_prec`.
- R5: Mode 0 rounds to nearest with ties to even. Mode 1 rounds toward zero, mode 2 toward minus infinity and mode 3 toward plus infinity. Rounding happens at the lowest kept bit, using guard, round and sticky bits from the whole shift.
- R6: The sign is passed to `out_sign` unchanged. The magnitude is rounded unsigned, and the directed modes look at the sign to pick the direction.
- R7: A shift of 65 places or more leaves a zero mantissa, with every lost bit counted as sticky. Such a result is inexact.
- R8: When rounding carries into the integer bit, the result is the smallest normal number: mantissa 0x8000000000000000 at the threshold exponent. A carry out of all 64 bits shifts the mantissa back and adds one to the exponent.
- R9: With `in_to_mem` at 1 and effective precision single or double, the output exponent is one less whenever bit 63 of the rounded mantissa is 0.
- R10: For a register destination (`in_to_mem` at 0), `out_zero` is 1 exactly when the 64-bit mantissa is zero, and `out_neg` equals the sign. For a memory destination, both flags are 0.
- R11: `out_inexact` is 1 exactly when any guard, round or sticky bit is set.
- R12: `out_valid` rises n+1 clock edges after the accepting edge, where n is the smaller of the exponent shortfall and 65. The result stays stable, and `in_ready` stays 0, until `out_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand taken on this edge |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand biased exponent |
| in_mant | input | 64 | Operand mantissa, integer bit at 63 |
| in_mode | input | 2 | Rounding mode code |
| in_prec | input | 2 | Rounding precision code |
| in_op | input | 7 | Operation code field |
| in_to_mem | input | 1 | 1 = memory destination, 0 = register |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed on this edge |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result exponent |
| out_mant | output | 64 | Result mantissa |
| out_inexact | output | 1 | Rounding lost information |
| out_zero | output | 1 | Zero condition flag |
| out_neg | output | 1 | Negative condition flag |

## Verification
The bench offers an operand and counts clock edges from the edge that accepts it. All result fields and flags are due on the same edge, the (n+1)-th, where n is the shift length capped at 65. Outputs are sampled just after each edge. The bench compares the counted latency against the value it expects, so a step lost or added in the shift loop shows up even when the data comes out right. A held-off `out_ready` checks that the result and the busy indication stay put over several edges.

// File: rtl/ufr_pkg.sv
package ufr_pkg;
  localparam int EXP_W    = 15;
  localparam int MAN_W    = 64;
  localparam int SGL_BITS = 24;
  localparam int DBL_BITS = 53;
  localparam logic [EXP_W-1:0] EXT_THR = 15'h0000;
  localparam logic [EXP_W-1:0] SGL_THR = 15'h3F81;
  localparam logic [EXP_W-1:0] DBL_THR = 15'h3C01;
  localparam logic [6:0] OP_SGL_DIV = 7'h30;
  localparam logic [6:0] OP_SGL_MUL = 7'h33;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_DOWN = 2'd2,
    RND_UP   = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    PR_EXT = 2'd0,
    PR_SGL = 2'd1,
    PR_DBL = 2'd2,
    PR_RSV = 2'd3
  } prec_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } ufr_state_e;

  function automatic prec_e eff_prec(input logic [1:0] prec, input logic [6:0] op);
    if (op == OP_SGL_DIV || op == OP_SGL_MUL) return PR_SGL;
    case (prec)
      2'd1:    return PR_SGL;
      2'd2:    return PR_DBL;
      default: return PR_EXT;
    endcase
  endfunction

  function automatic logic [EXP_W-1:0] prec_thr(input prec_e p);
    case (p)
      PR_SGL:  return SGL_THR;
      PR_DBL:  return DBL_THR;
      default: return EXT_THR;
    endcase
  endfunction

  function automatic int prec_lsb(input prec_e p);
    case (p)
      PR_SGL:  return MAN_W - SGL_BITS;
      PR_DBL:  return MAN_W - DBL_BITS;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/ufr_denorm_step.sv
module ufr_denorm_step
  import ufr_pkg::*;
(
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  input  logic             xg_i,
  input  logic             stk_i,
  input  logic [EXP_W-1:0] thr_i,
  output logic             done_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o,
  output logic             xg_o,
  output logic             stk_o,
  output logic [EXP_W-1:0] exp_fin_o
);
  logic below;
  logic drained;

  always_comb begin
    below     = (exp_i < thr_i);
    drained   = (man_i == '0) && !xg_i;
    done_o    = !below || drained;
    exp_o     = exp_i + 1'b1;
    man_o     = man_i >> 1;
    xg_o      = man_i[0];
    stk_o     = stk_i | xg_i;
    exp_fin_o = below ? thr_i : exp_i;
  end
endmodule

// File: rtl/ufr_round.sv
module ufr_round
  import ufr_pkg::*;
(
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  input  logic             xg_i,
  input  logic             stk_i,
  input  prec_e            prec_i,
  input  rnd_mode_e        mode_i,
  input  logic             mem_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o,
  output logic             inexact_o,
  output logic             zero_o,
  output logic             neg_o
);
  int               lsb;
  logic [MAN_W-1:0] unit;
  logic [MAN_W-1:0] low_mask;
  logic [MAN_W-1:0] trunc;
  logic             grd;
  logic             rest;
  logic             lsb_bit;
  logic             inc;
  logic [MAN_W:0]   sum;
  logic [EXP_W-1:0] exp_r;

  always_comb begin
    lsb      = prec_lsb(prec_i);
    unit     = {{(MAN_W-1){1'b0}}, 1'b1} << lsb;
    low_mask = unit - 1'b1;
    trunc    = man_i & ~low_mask;
    lsb_bit  = |(man_i & unit);
    if (lsb == 0) begin
      grd  = xg_i;
      rest = stk_i;
    end else begin
      grd  = |(man_i & (unit >> 1));
      rest = |(man_i & (low_mask >> 1)) | xg_i | stk_i;
    end
    inexact_o = grd | rest;
    case (mode_i)
      RND_NEAR: inc = grd & (rest | lsb_bit);
      RND_DOWN: inc = sign_i & inexact_o;
      RND_UP:   inc = !sign_i & inexact_o;
      default:  inc = 1'b0;
    endcase
    sum = {1'b0, trunc} + (inc ? {1'b0, unit} : '0);
    if (sum[MAN_W]) begin
      man_o = sum[MAN_W:1];
      exp_r = exp_i + 1'b1;
    end else begin
      man_o = sum[MAN_W-1:0];
      exp_r = exp_i;
    end
    if (mem_i && (prec_i == PR_SGL || prec_i == PR_DBL) && !man_o[MAN_W-1])
      exp_o = exp_r - 1'b1;
    else
      exp_o = exp_r;
    zero_o = !mem_i && (man_o[MAN_W-1:MAN_W/2] == '0) && (man_o[MAN_W/2-1:0] == '0);
    neg_o  = !mem_i && sign_i;
  end
endmodule

// File: rtl/ufr_top.sv
module ufr_top
  import ufr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [MAN_W-1:0] in_mant,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       in_prec,
  input  logic [6:0]       in_op,
  input  logic             in_to_mem,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_mant,
  output logic             out_inexact,
  output logic             out_zero,
  output logic             out_neg
);
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ufr_state_e       st_q, st_d;
  logic             sign_q, xg_q, stk_q, mem_q;
  logic [EXP_W-1:0] exp_q;
  logic [MAN_W-1:0] man_q;
  prec_e            prec_q;
  rnd_mode_e        mode_q;

  logic             step_done, step_xg, step_stk;
  logic [EXP_W-1:0] step_exp, step_fin;
  logic [MAN_W-1:0] step_man;
  logic [EXP_W-1:0] rnd_exp;
  logic [MAN_W-1:0] rnd_man;
  logic             rnd_inexact, rnd_zero, rnd_neg;
  logic             load_en, step_en, cap_en;

  ufr_denorm_step u_step (
    .exp_i     (exp_q),
    .man_i     (man_q),
    .xg_i      (xg_q),
    .stk_i     (stk_q),
    .thr_i     (prec_thr(prec_q)),
    .done_o    (step_done),
    .exp_o     (step_exp),
    .man_o     (step_man),
    .xg_o      (step_xg),
    .stk_o     (step_stk),
    .exp_fin_o (step_fin)
  );

  ufr_round u_round (
    .sign_i    (sign_q),
    .exp_i     (step_fin),
    .man_i     (man_q),
    .xg_i      (xg_q),
    .stk_i     (stk_q),
    .prec_i    (prec_q),
    .mode_i    (mode_q),
    .mem_i     (mem_q),
    .exp_o     (rnd_exp),
    .man_o     (rnd_man),
    .inexact_o (rnd_inexact),
    .zero_o    (rnd_zero),
    .neg_o     (rnd_neg)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (in_valid)  st_d = ST_SHIFT;
      ST_SHIFT: if (step_done) st_d = ST_DONE;
      ST_DONE:  if (out_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign load_en   = in_ready && in_valid;
  assign step_en   = (st_q == ST_SHIFT) && !step_done;
  assign cap_en    = (st_q == ST_SHIFT) && step_done;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      sign_q <= in_sign;
      exp_q  <= in_exp;
      man_q  <= in_mant;
      xg_q   <= 1'b0;
      stk_q  <= 1'b0;
      prec_q <= eff_prec(in_prec, in_op);
      mode_q <= rnd_mode_e'(in_mode);
      mem_q  <= in_to_mem;
    end else if (step_en) begin
      exp_q  <= step_exp;
      man_q  <= step_man;
      xg_q   <= step_xg;
      stk_q  <= step_stk;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      out_sign    <= sign_q;
      out_exp     <= rnd_exp;
      out_mant    <= rnd_man;
      out_inexact <= rnd_inexact;
      out_zero    <= rnd_zero;
      out_neg     <= rnd_neg;
    end
  end

  assert_step_exp_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    step_en |=> (exp_q == $past(exp_q) + 1'b1));

  assert_exact_keep_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (cap_en && !rnd_inexact) |=> (out_mant == $past(man_q)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mant) && $stable(out_exp)));

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !(in_ready && out_valid));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_zero) |-> (out_mant == '0));
endmodule

// File: tb/ufr_top_bench.sv
module ufr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [14:0] in_exp = '0;
  logic [63:0] in_mant = '0;
  logic [1:0]  in_mode = '0;
  logic [1:0]  in_prec = '0;
  logic [6:0]  in_op = '0;
  logic        in_to_mem = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_sign;
  logic [14:0] out_exp;
  logic [63:0] out_mant;
  logic        out_inexact, out_zero, out_neg;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ufr_top u_ufr_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_mode(in_mode),
    .in_prec(in_prec), .in_op(in_op), .in_to_mem(in_to_mem),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant), .out_inexact(out_inexact),
    .out_zero(out_zero), .out_neg(out_neg)
  );

  typedef struct packed {
    logic        s;
    logic [14:0] e;
    logic [63:0] m;
    logic [1:0]  mode;
    logic [1:0]  prec;
    logic [6:0]  op;
    logic        mem;
    logic        xs;
    logic [14:0] xe;
    logic [63:0] xm;
    logic        xi;
    logic        xz;
    logic        xn;
    logic [7:0]  xlat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R2: already at single threshold, no shift
    '{1'b0,15'h3F81,64'h8000000000000000,2'd0,2'd1,7'h00,1'b0, 1'b0,15'h3F81,64'h8000000000000000,1'b0,1'b0,1'b0,8'd1,4'd2},
    // R5: nearest, tie goes to even
    '{1'b0,15'h3F80,64'h8000010000000000,2'd0,2'd1,7'h00,1'b0, 1'b0,15'h3F81,64'h4000000000000000,1'b1,1'b0,1'b0,8'd2,4'd5},
    // R5: toward plus, positive
    '{1'b0,15'h3F80,64'h8000010000000000,2'd3,2'd1,7'h00,1'b0, 1'b0,15'h3F81,64'h4000010000000000,1'b1,1'b0,1'b0,8'd2,4'd5},
    // R6: toward minus, negative
    '{1'b1,15'h3F80,64'h8000010000000000,2'd2,2'd1,7'h00,1'b0, 1'b1,15'h3F81,64'h4000010000000000,1'b1,1'b0,1'b1,8'd2,4'd6},
    // R6: toward plus, negative
    '{1'b1,15'h3F80,64'h8000010000000000,2'd3,2'd1,7'h00,1'b0, 1'b1,15'h3F81,64'h4000000000000000,1'b1,1'b0,1'b1,8'd2,4'd6},
    // R3: double, three steps, round up
    '{1'b0,15'h3BFE,64'hFFFFFFFFFFFFFFFF,2'd0,2'd2,7'h00,1'b0, 1'b0,15'h3C01,64'h2000000000000000,1'b1,1'b0,1'b0,8'd4,4'd3},
    // R8: carry into integer bit, memory store keeps exponent
    '{1'b0,15'h3F80,64'hFFFFFF8000000000,2'd0,2'd1,7'h00,1'b1, 1'b0,15'h3F81,64'h8000000000000000,1'b1,1'b0,1'b0,8'd2,4'd8},
    // R9: single denormal to memory, exponent minus one
    '{1'b0,15'h3F80,64'h8000010000000000,2'd0,2'd1,7'h00,1'b1, 1'b0,15'h3F80,64'h4000000000000000,1'b1,1'b0,1'b0,8'd2,4'd9},
    // R4: op 0x33 forces single over extended
    '{1'b0,15'h3F80,64'h8000010000000000,2'd0,2'd0,7'h33,1'b0, 1'b0,15'h3F81,64'h4000000000000000,1'b1,1'b0,1'b0,8'd2,4'd4},
    // R4: op 0x30 forces single over double
    '{1'b0,15'h3F80,64'h8000010000000000,2'd0,2'd2,7'h30,1'b0, 1'b0,15'h3F81,64'h4000000000000000,1'b1,1'b0,1'b0,8'd2,4'd4},
    // R7: huge shift, toward zero gives zero
    '{1'b0,15'h0001,64'h8000000000000000,2'd1,2'd1,7'h00,1'b0, 1'b0,15'h3F81,64'h0000000000000000,1'b1,1'b1,1'b0,8'd66,4'd7},
    // R7: huge shift, toward plus gives one unit
    '{1'b0,15'h0001,64'h8000000000000000,2'd3,2'd1,7'h00,1'b0, 1'b0,15'h3F81,64'h0000010000000000,1'b1,1'b0,1'b0,8'd66,4'd7},
    // R3: extended, exact
    '{1'b0,15'h0005,64'h8000000000000001,2'd0,2'd0,7'h00,1'b0, 1'b0,15'h0005,64'h8000000000000001,1'b0,1'b0,1'b0,8'd1,4'd3},
    // R3: code 3 acts as extended
    '{1'b0,15'h0005,64'h8000000000000001,2'd0,2'd3,7'h00,1'b0, 1'b0,15'h0005,64'h8000000000000001,1'b0,1'b0,1'b0,8'd1,4'd3},
    // R9: double denormal to memory
    '{1'b0,15'h3BFE,64'hFFFFFFFFFFFFFFFF,2'd0,2'd2,7'h00,1'b1, 1'b0,15'h3C00,64'h2000000000000000,1'b1,1'b0,1'b0,8'd4,4'd9},
    // R10: memory store clears flags even for negative zero
    '{1'b1,15'h0001,64'h8000000000000000,2'd1,2'd1,7'h00,1'b1, 1'b1,15'h3F80,64'h0000000000000000,1'b1,1'b0,1'b0,8'd66,4'd10},
    // R8: carry out of all 64 bits, exponent plus one
    '{1'b0,15'h3F81,64'hFFFFFF8000000000,2'd0,2'd1,7'h00,1'b0, 1'b0,15'h3F82,64'h8000000000000000,1'b1,1'b0,1'b0,8'd1,4'd8},
    // R4: op 0x31 not forced, double used
    '{1'b0,15'h3F80,64'h8000010000000000,2'd0,2'd2,7'h31,1'b0, 1'b0,15'h3F80,64'h8000010000000000,1'b0,1'b0,1'b0,8'd1,4'd4}
  };

  task automatic chk(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int lat;
    @(negedge clk);
    in_sign = v.s; in_exp = v.e; in_mant = v.m; in_mode = v.mode;
    in_prec = v.prec; in_op = v.op; in_to_mem = v.mem; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      #1 lat++;
      if (out_valid) break;
    end
    $display("vector %0d", idx);
    chk("latency R12", 12, 64'(lat), 64'(v.xlat));
    chk("sign", v.req, 64'(out_sign), 64'(v.xs));
    chk("exponent", v.req, 64'(out_exp), 64'(v.xe));
    chk("mantissa", v.req, out_mant, v.xm);
    chk("inexact R11", 11, 64'(out_inexact), 64'(v.xi));
    chk("zero flag R10", 10, 64'(out_zero), 64'(v.xz));
    chk("neg flag R10", 10, 64'(out_neg), 64'(v.xn));
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: idle after reset
    chk("reset in_ready R1", 1, 64'(in_ready), 64'd1);
    chk("reset out_valid R1", 1, 64'(out_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R12: hold result while out_ready is low
    @(negedge clk);
    out_ready = 1'b0;
    in_sign = 1'b0; in_exp = 15'h3F80; in_mant = 64'h8000010000000000;
    in_mode = 2'd3; in_prec = 2'd1; in_op = 7'h00; in_to_mem = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("held valid R12", 12, 64'(out_valid), 64'd1);
    repeat (3) @(posedge clk);
    #1;
    chk("still valid R12", 12, 64'(out_valid), 64'd1);
    chk("busy R12", 12, 64'(in_ready), 64'd0);
    chk("held mantissa R12", 12, out_mant, 64'h4000010000000000);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("released R12", 12, 64'(out_valid), 64'd0);
    chk("idle again R12", 12, 64'(in_ready), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule